// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a general-purpose I/O port of 32 pins sitting behind a small single-cycle register bus. Software sets each pin's output value and direction, reads back the synchronized level of every pad, and configures a per-pin interrupt detector. The pad buffers stay outside the block: the port only produces an output value and an output-enable per pin and accepts the raw pad level.

Each pin's detector fires on a low level, a high level, a rising edge or a falling edge. A detection sets a sticky status bit. Software clears a status bit by writing a one to it. Two interrupt lines leave the block. One serves pins 0 to 15 and the other serves pins 16 to 31. Each line is the OR of the status bits that are also enabled in the mask register.

The register bus has no handshake. A write takes effect at the clock edge where `bus_we` is high, and read data is a combinational function of `bus_addr`. The bus carries no streaming data, so it has no valid/ready back-pressure.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero. All pins are inputs (`pin_oe` = 0), every mask bit is clear, every trigger code is 0 (low level), and both interrupt outputs are low.
- R2: The output-value register sits at offset 0x00 and the direction register at 0x04, and both read back what was written. `pin_oe` equals the direction register. `pin_out` bit n equals the output-value bit n when direction bit n is 1, and is 0 otherwise.
- R3: Offset 0x08 returns the level of every pin whatever its direction, delayed by a two-flop synchronizer. A pin change driven before clock edge k is not visible after edge k and is visible after edge k+1. Writes to 0x08 have no effect.
- R4: Trigger codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Pin n (n < 16) uses bits 2n+1:2n of the register at 0x0C. Pin n (n ≥ 16) uses bits 2(n-16)+1:2(n-16) of the register at 0x10. An edge compares the current synchronized sample with the previous one.
- R5: In the status register at 0x18, writing 1 to a bit clears it and writing 0 leaves it unchanged. A status bit sets on a detection whatever the mask value.
- R6: A level-triggered status bit that is cleared while its level is still present is set again.
- R7: When a clear write and a new detection hit the same status bit at the same clock edge, the bit ends up set.
- R8: The mask register is at 0x14, where 1 enables. `irq_lo` is high exactly when some pin 0 to 15 has both its status bit and its mask bit set. `irq_hi` does the same for pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Raw pad levels |
| pin_out | output | 32 | Value driven by each pin while it is an output |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The assertions assume that reset is applied for at least one clock edge and that `bus_we`, `bus_addr` and `bus_wdata` are stable around each rising edge. They make no assumption about when `pin_in` changes, because the synchronizer absorbs asynchronous pad changes. The bench drives the bus and the pads only at falling edges. Before it changes the trigger setup it holds the pads stable for several cycles and clears the status register, so that an expected status value depends only on the old and new pad levels and the trigger codes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int OFS_DOUT   = 'h00;
  localparam int OFS_DIR    = 'h04;
  localparam int OFS_PAD    = 'h08;
  localparam int OFS_CFG_LO = 'h0C;
  localparam int OFS_CFG_HI = 'h10;
  localparam int OFS_MASK   = 'h14;
  localparam int OFS_STAT   = 'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  output logic       hit
);
  always_comb begin
    unique case (trig_e'(mode))
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int HALF = N / 2;

  logic [N-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | hit;
  end

  assign pend   = stat & mask;
  assign irq_lo = |pend[HALF-1:0];
  assign irq_hi = |pend[N-1:HALF];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = N_PINS / 2;

  logic [N_PINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
  logic [N_PINS-1:0] pad_q, prev_q, hit, clr, stat_q;
  logic              sel_dout, sel_dir, sel_lo, sel_hi, sel_mask, sel_stat;

  assign sel_dout = bus_addr == ADDR_W'(OFS_DOUT);
  assign sel_dir  = bus_addr == ADDR_W'(OFS_DIR);
  assign sel_lo   = bus_addr == ADDR_W'(OFS_CFG_LO);
  assign sel_hi   = bus_addr == ADDR_W'(OFS_CFG_HI);
  assign sel_mask = bus_addr == ADDR_W'(OFS_MASK);
  assign sel_stat = bus_addr == ADDR_W'(OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (bus_we) begin
      if (sel_dout) dout_q   <= bus_wdata;
      if (sel_dir)  dir_q    <= bus_wdata;
      if (sel_lo)   cfg_lo_q <= bus_wdata;
      if (sel_hi)   cfg_hi_q <= bus_wdata;
      if (sel_mask) mask_q   <= bus_wdata;
    end
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pad_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pad_q;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic [1:0] mode;
    if (i < HALF) begin : g_lo
      assign mode = cfg_lo_q[2*i +: 2];
    end else begin : g_hi
      assign mode = cfg_hi_q[2*(i-HALF) +: 2];
    end
    gpio_pin_det u_det (
      .mode(mode),
      .cur (pad_q[i]),
      .prev(prev_q[i]),
      .hit (hit[i])
    );
  end

  assign clr = (bus_we && sel_stat) ? bus_wdata : '0;

  gpio_irq_stat #(.N(N_PINS)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .clr   (clr),
    .mask  (mask_q),
    .stat  (stat_q),
    .irq_lo(irq_lo),
    .irq_hi(irq_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_dout) bus_rdata = dout_q;
    if (sel_dir)  bus_rdata = dir_q;
    if (bus_addr == ADDR_W'(OFS_PAD)) bus_rdata = pad_q;
    if (sel_lo)   bus_rdata = cfg_lo_q;
    if (sel_hi)   bus_rdata = cfg_hi_q;
    if (sel_mask) bus_rdata = mask_q;
    if (sel_stat) bus_rdata = stat_q;
  end

  assign pin_out = dout_q & dir_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [N_PINS-1:0] stat,
  input logic [N_PINS-1:0] mask
);
  localparam int HALF = N_PINS / 2;

  logic seen_q;
  logic stat_wr;
  always_ff @(posedge clk) seen_q <= 1'b1;
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFS_STAT));

  AST_RESET_QUIET: assert property (@(posedge clk)
    (seen_q && !rst_n) |-> (pin_oe == '0 && !irq_lo && !irq_hi)); // R1

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(bus_wdata))); // R2

  AST_OUT_ONLY_WHEN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R2

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((($past(stat)) & ~stat) == '0)); // R5

  AST_STAT_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (($past(stat) & ~$past(bus_wdata) & ~stat) == '0)); // R5

  AST_IRQ_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (mask[HALF-1:0] != '0)); // R8

  AST_IRQ_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (mask[N_PINS-1:HALF] != '0)); // R8
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .stat     (stat_q),
  .mask     (mask_q)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_lo, irq_hi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] cl, input logic [31:0] ch,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] code;
      code = (i < 16) ? cl[2*i +: 2] : ch[2*(i-16) +: 2];
      case (code)
        2'd0: r[i] = ~a[i] | ~b[i];
        2'd1: r[i] = a[i] | b[i];
        2'd2: r[i] = ~a[i] & b[i];
        default: r[i] = a[i] & ~b[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, dr, a, b, cl, ch, m, e;
    void'($urandom(32'h5EED_0042));
    idle(2);
    // R1 reset state, sampled while reset is held
    for (int k = 0; k < 7; k++) begin
      bus_addr = 5'(4 * k);
      #1 check("R1 reg", bus_rdata, 32'h0);
    end
    check("R1 oe", pin_oe, 32'h0);
    check("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 output value and direction
    for (int k = 0; k < 3; k++) begin
      d = $urandom; dr = $urandom;
      wr(5'h00, d); wr(5'h04, dr);
      rd(5'h00, v); check("R2 dout readback", v, d);
      rd(5'h04, v); check("R2 dir readback", v, dr);
      check("R2 pin_oe", pin_oe, dr);
      check("R2 pin_out", pin_out, d & dr);
    end

    // R3 pad status latency and read-only behaviour
    a = $urandom;
    @(negedge clk); pin_in = a;
    @(negedge clk); bus_addr = 5'h08; #1 check("R3 not yet visible", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R3 visible after two edges", bus_rdata, a);
    wr(5'h08, ~a);
    rd(5'h08, v); check("R3 write ignored", v, a);

    // R4 R8 randomized trigger codes, masks and pad transitions
    for (int k = 0; k < 40; k++) begin
      a = $urandom; b = $urandom; cl = $urandom; ch = $urandom; m = $urandom;
      if (k < 4) begin cl = {16{2'(k)}}; ch = {16{2'(k)}}; end
      @(negedge clk); pin_in = a;
      wr(5'h0C, cl); wr(5'h10, ch); wr(5'h14, m);
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      @(negedge clk); pin_in = b;
      idle(4);
      e = exp_stat(cl, ch, a, b);
      rd(5'h18, v); check("R4 status", v, e);
      check("R8 irq_lo", {31'h0, irq_lo}, {31'h0, |(e[15:0] & m[15:0])});
      check("R8 irq_hi", {31'h0, irq_hi}, {31'h0, |(e[31:16] & m[31:16])});
    end

    // R5 write-one clears, write-zero keeps
    wr(5'h14, 32'h0);
    wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'hFFFF_FFFF;
    idle(4);
    rd(5'h18, v); check("R5 rise sets", v, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0000_FFFF);
    rd(5'h18, v); check("R5 partial clear", v, 32'hFFFF_0000);
    wr(5'h18, 32'h0);
    rd(5'h18, v); check("R5 zero write keeps", v, 32'hFFFF_0000);

    // R7 detection and clear at the same edge
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); check("R7 pre-clear", v, 32'h0);
    @(negedge clk); pin_in = 32'h0000_8001;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h18; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_we = 1'b0;
    rd(5'h18, v); check("R7 detection wins", v, 32'h0000_8001);

    // R6 level re-set after clear while active
    wr(5'h0C, 32'h5555_5555); wr(5'h10, 32'h5555_5555);
    @(negedge clk); pin_in = 32'hF000_000F;
    idle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); check("R6 level re-sets", v, 32'hF000_000F);

    // R8 single-half interrupt
    wr(5'h14, 32'h1000_0000);
    @(negedge clk); #1 check("R8 only hi", {30'h0, irq_hi, irq_lo}, 32'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule